// File: doc/BRIEF.md
# Branch and Jump Target Unit

This unit resolves control transfers for a 64-bit RISC core whose instructions are all 32 bits wide and word aligned. Each cycle it can accept one decoded instruction word, along with the current program counter as a 62-bit word address and the two register read values. One clock later it reports three things. First, whether the fetch stream must be redirected and where to. Second, the link value and the register it goes to. Third, what happened in an internal eight-entry return-prediction stack.

Three instruction groups are handled. Conditional PC-relative branches test one register against zero. Unconditional branches come in two forms: plain branch and branch-to-subroutine. Register-indirect jumps come in four kinds, and the kind only changes how the return stack is used. Any other opcode passes through as sequential flow. Internally the unit is decode, a target adder, the return stack, and an output register stage. It has no multi-cycle state beyond the stack.

Top module: `redirect_unit`

## Requirements
- R1: While reset is low and right after it, out_valid_o, taken_o, link_we_o, ras_push_o and ras_pop_o are 0. The return stack starts with all eight entries at zero, so a pop straight after reset predicts 0.
- R2: All results appear exactly one clock after the edge that samples valid_i high. An instruction presented with valid_i low produces out_valid_o = 0 and taken_o = 0 and leaves the return stack unchanged.
- R3: Conditional branches use opcode bits 31:26 = 0x38 (taken when Ra == 0), 0x39 (Ra != 0), 0x3A (Ra < 0), 0x3B (Ra >= 0), 0x3C (Ra <= 0) and 0x3D (Ra > 0). All comparisons are signed, with Ra in bits 25:21. These branches never write a link.
- R4: The PC-relative target is (PC + 4) plus the 21-bit displacement in bits 20:0. The displacement is sign-extended and shifted left by 2, and the sum wraps modulo 2^64. When no redirect happens, next_pc_o is PC + 4.
- R5: Opcode 0x30 (plain branch) and opcode 0x34 (branch-to-subroutine) are always taken and write PC + 4 to Ra.
- R6: Branch-to-subroutine pushes PC + 4 onto the return stack. The plain branch leaves the stack untouched.
- R7: Opcode 0x1A is a jump. Its target is Rb (bits 20:16) with the two low bits cleared, and it writes PC + 4 to Ra. When Ra and Rb name the same register, the target uses the old Rb value.
- R8: Bits 15:14 of a jump select its kind. 00 is plain and leaves the stack alone. 01 is call and pushes PC + 4. 10 is return and pops. 11 is coroutine: it pops, then pushes PC + 4 in place. Bits 13:0 have no effect.
- R9: The return stack holds 8 entries and wraps. A ninth push overwrites the oldest entry, and pops walk back through the slots modulo 8.
- R10: A link whose destination is register 31 is suppressed: link_we_o stays 0, while the stack action still takes place.
- R11: Any other opcode, including 0x3E and 0x3F, is not taken, writes no link and makes no stack request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 62 | Word address of the instruction |
| ra_val_i | input | 64 | Value read from register Ra |
| rb_val_i | input | 64 | Value read from register Rb |
| out_valid_o | output | 1 | Results below belong to last cycle's instruction |
| taken_o | output | 1 | Fetch must redirect to next_pc_o |
| next_pc_o | output | 64 | Byte address of the next instruction |
| link_we_o | output | 1 | Link write request |
| link_reg_o | output | 5 | Link destination register |
| link_data_o | output | 64 | Link value (PC + 4) |
| ras_push_o | output | 1 | Return stack was pushed |
| ras_pop_o | output | 1 | Return stack was popped |
| ras_pred_o | output | 64 | Popped return prediction, 0 when no pop |

## Verification
The bench covers every zero-compare condition on zero, positive and negative operands. A sign or boundary slip here would show up as a flipped taken flag. A negative displacement that wraps below address zero is included; an adder that dropped the sign extension would land far forward instead. A jump with Ra equal to Rb and low bits set in Rb is included; a unit that used the written-back link value or kept the low bits would jump to the wrong address. Return-stack coverage includes coroutine swaps, hint bits, link suppression to register 31 and a ninth push. A wrong pointer step or a missing wrap would return the wrong prediction on the following pops.

// File: rtl/redirect_pkg.sv
package redirect_pkg;

    localparam logic [5:0] OP_JUMP = 6'h1A;
    localparam logic [5:0] OP_BR   = 6'h30;
    localparam logic [5:0] OP_BSR  = 6'h34;
    localparam logic [5:0] OP_BEQ  = 6'h38;
    localparam logic [5:0] OP_BNE  = 6'h39;
    localparam logic [5:0] OP_BLT  = 6'h3A;
    localparam logic [5:0] OP_BGE  = 6'h3B;
    localparam logic [5:0] OP_BLE  = 6'h3C;
    localparam logic [5:0] OP_BGT  = 6'h3D;

    localparam logic [4:0] ZERO_REG = 5'd31;

    typedef enum logic [3:0] {
        XFER_NONE,
        XFER_COND,
        XFER_BR,
        XFER_BSR,
        XFER_JMP,
        XFER_CALL,
        XFER_RET,
        XFER_CORO
    } xfer_e;

    typedef enum logic [1:0] {
        JK_PLAIN = 2'b00,
        JK_CALL  = 2'b01,
        JK_RET   = 2'b10,
        JK_CORO  = 2'b11
    } jkind_e;

endpackage

// File: rtl/redirect_decode.sv
module redirect_decode
    import redirect_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int DISPW = 21
) (
    input  logic [31:0]      instr,
    input  logic [XLEN-1:0]  ra_val,
    output xfer_e            kind,
    output logic             take,
    output logic             link_we,
    output logic [4:0]       ra_idx,
    output logic [DISPW-1:0] disp,
    output logic             use_reg,
    output logic             push,
    output logic             pop
);

    logic [5:0] opcode;
    logic       is_zero;
    logic       is_neg;
    logic       cond_hit;
    jkind_e     jkind;

    assign opcode  = instr[31:26];
    assign ra_idx  = instr[25:21];
    assign disp    = instr[DISPW-1:0];
    assign jkind   = jkind_e'(instr[15:14]);
    assign is_zero = (ra_val == '0);
    assign is_neg  = ra_val[XLEN-1];

    always_comb begin
        unique case (opcode)
            OP_BEQ:  cond_hit = is_zero;
            OP_BNE:  cond_hit = !is_zero;
            OP_BLT:  cond_hit = is_neg;
            OP_BGE:  cond_hit = !is_neg;
            OP_BLE:  cond_hit = is_neg || is_zero;
            OP_BGT:  cond_hit = !is_neg && !is_zero;
            default: cond_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (opcode)
            OP_BEQ, OP_BNE, OP_BLT,
            OP_BGE, OP_BLE, OP_BGT: kind = XFER_COND;
            OP_BR:                  kind = XFER_BR;
            OP_BSR:                 kind = XFER_BSR;
            OP_JUMP: begin
                unique case (jkind)
                    JK_PLAIN: kind = XFER_JMP;
                    JK_CALL:  kind = XFER_CALL;
                    JK_RET:   kind = XFER_RET;
                    JK_CORO:  kind = XFER_CORO;
                    default:  kind = XFER_JMP;
                endcase
            end
            default:                kind = XFER_NONE;
        endcase
    end

    always_comb begin
        take    = 1'b0;
        use_reg = 1'b0;
        push    = 1'b0;
        pop     = 1'b0;
        link_we = 1'b0;
        unique case (kind)
            XFER_COND: take = cond_hit;
            XFER_BR: begin
                take    = 1'b1;
                link_we = 1'b1;
            end
            XFER_BSR: begin
                take    = 1'b1;
                link_we = 1'b1;
                push    = 1'b1;
            end
            XFER_JMP: begin
                take    = 1'b1;
                use_reg = 1'b1;
                link_we = 1'b1;
            end
            XFER_CALL: begin
                take    = 1'b1;
                use_reg = 1'b1;
                link_we = 1'b1;
                push    = 1'b1;
            end
            XFER_RET: begin
                take    = 1'b1;
                use_reg = 1'b1;
                link_we = 1'b1;
                pop     = 1'b1;
            end
            XFER_CORO: begin
                take    = 1'b1;
                use_reg = 1'b1;
                link_we = 1'b1;
                push    = 1'b1;
                pop     = 1'b1;
            end
            default: take = 1'b0;
        endcase
        if (ra_idx == ZERO_REG) begin
            link_we = 1'b0;
        end
    end

endmodule

// File: rtl/redirect_target.sv
module redirect_target #(
    parameter int XLEN  = 64,
    parameter int DISPW = 21
) (
    input  logic [XLEN-3:0]  pc_word,
    input  logic [DISPW-1:0] disp,
    input  logic [XLEN-1:0]  rb_val,
    input  logic             use_reg,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  target
);

    localparam int EXTW = XLEN - DISPW - 2;

    logic [XLEN-1:0] pc_byte;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] reg_tgt;

    assign pc_byte = {pc_word, 2'b00};
    assign seq_pc  = pc_byte + XLEN'(4);
    assign offset  = {{EXTW{disp[DISPW-1]}}, disp, 2'b00};
    assign rel_tgt = seq_pc + offset;
    assign reg_tgt = {rb_val[XLEN-1:2], 2'b00};
    assign target  = use_reg ? reg_tgt : rel_tgt;

endmodule

// File: rtl/redirect_ras.sv
module redirect_ras #(
    parameter int XLEN  = 64,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [XLEN-1:0] push_val,
    output logic [XLEN-1:0] top_val
);

    localparam int PW = $clog2(DEPTH);

    logic [XLEN-1:0] slots [DEPTH];
    logic [PW-1:0]   sp;
    logic [PW-1:0]   top_idx;

    assign top_idx = sp - PW'(1);
    assign top_val = slots[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else begin
            unique case ({push, pop})
                2'b10: begin
                    slots[sp] <= push_val;
                    sp        <= sp + PW'(1);
                end
                2'b01: sp <= top_idx;
                2'b11: slots[top_idx] <= push_val;
                default: sp <= sp;
            endcase
        end
    end

    a_r9_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (sp == $past(sp) + PW'(1)));

    a_r9_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (sp == $past(sp) - PW'(1)));

    a_r8_swap_holds_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(sp));

    a_r8_swap_writes_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (top_val == $past(push_val)));

endmodule

// File: rtl/redirect_unit.sv
module redirect_unit
    import redirect_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int DISPW     = 21,
    parameter int RAS_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [31:0]      instr_i,
    input  logic [XLEN-3:0]  pc_i,
    input  logic [XLEN-1:0]  ra_val_i,
    input  logic [XLEN-1:0]  rb_val_i,
    output logic             out_valid_o,
    output logic             taken_o,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             link_we_o,
    output logic [4:0]       link_reg_o,
    output logic [XLEN-1:0]  link_data_o,
    output logic             ras_push_o,
    output logic             ras_pop_o,
    output logic [XLEN-1:0]  ras_pred_o
);

    xfer_e            kind;
    logic             take;
    logic             link_req;
    logic [4:0]       ra_idx;
    logic [DISPW-1:0] disp;
    logic             use_reg;
    logic             push_req;
    logic             pop_req;
    logic [XLEN-1:0]  seq_pc;
    logic [XLEN-1:0]  target;
    logic [XLEN-1:0]  top_val;
    logic             do_push;
    logic             do_pop;

    redirect_decode #(.XLEN(XLEN), .DISPW(DISPW)) u_decode (
        .instr   (instr_i),
        .ra_val  (ra_val_i),
        .kind    (kind),
        .take    (take),
        .link_we (link_req),
        .ra_idx  (ra_idx),
        .disp    (disp),
        .use_reg (use_reg),
        .push    (push_req),
        .pop     (pop_req)
    );

    redirect_target #(.XLEN(XLEN), .DISPW(DISPW)) u_target (
        .pc_word (pc_i),
        .disp    (disp),
        .rb_val  (rb_val_i),
        .use_reg (use_reg),
        .seq_pc  (seq_pc),
        .target  (target)
    );

    assign do_push = valid_i && push_req;
    assign do_pop  = valid_i && pop_req;

    redirect_ras #(.XLEN(XLEN), .DEPTH(RAS_DEPTH)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (seq_pc),
        .top_val  (top_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            taken_o     <= 1'b0;
            next_pc_o   <= '0;
            link_we_o   <= 1'b0;
            link_reg_o  <= '0;
            link_data_o <= '0;
            ras_push_o  <= 1'b0;
            ras_pop_o   <= 1'b0;
            ras_pred_o  <= '0;
        end else begin
            out_valid_o <= valid_i;
            taken_o     <= valid_i && take;
            next_pc_o   <= !valid_i ? '0 : (take ? target : seq_pc);
            link_we_o   <= valid_i && link_req;
            link_reg_o  <= (valid_i && link_req) ? ra_idx : '0;
            link_data_o <= (valid_i && link_req) ? seq_pc : '0;
            ras_push_o  <= do_push;
            ras_pop_o   <= do_pop;
            ras_pred_o  <= do_pop ? top_val : '0;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid_o && !taken_o && !link_we_o && !ras_push_o && !ras_pop_o));

    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> out_valid_o);

    a_r2_idle_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!taken_o && !ras_push_o && !ras_pop_o));

    a_r5_link_is_next: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (!link_we_o || (link_data_o == {$past(pc_i), 2'b00} + XLEN'(4))));

    a_r7_old_rb_target: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[31:26] == OP_JUMP) |=>
            (taken_o && next_pc_o[XLEN-1:2] == $past(rb_val_i[XLEN-1:2])));

    a_r10_no_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_reg_o != ZERO_REG));

    a_r11_stack_only_when_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_push_o || ras_pop_o) |-> taken_o);

endmodule

// File: tb/redirect_unit_bench.sv
module redirect_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [61:0] pc_i = '0;
    logic [63:0] ra_val_i = '0;
    logic [63:0] rb_val_i = '0;
    logic        out_valid_o, taken_o, link_we_o, ras_push_o, ras_pop_o;
    logic [63:0] next_pc_o, link_data_o, ras_pred_o;
    logic [4:0]  link_reg_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] mstk [8];
    logic [2:0]  msp = '0;

    always #2 clk = ~clk;

    redirect_unit u_redirect_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .pc_i(pc_i), .ra_val_i(ra_val_i), .rb_val_i(rb_val_i),
        .out_valid_o(out_valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
        .link_we_o(link_we_o), .link_reg_o(link_reg_o), .link_data_o(link_data_o),
        .ras_push_o(ras_push_o), .ras_pop_o(ras_pop_o), .ras_pred_o(ras_pred_o)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        exp_taken;
        logic [31:0] ins;
        logic [61:0] pc;
        logic [63:0] ra;
        logic [63:0] rb;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t TBL [NVEC] = '{
        '{"R3", 1'b1, {6'h38, 5'd1, 21'd5},        62'h100,  64'd0,  64'd0},
        '{"R3", 1'b0, {6'h38, 5'd1, 21'd5},        62'h100,  64'd1,  64'd0},
        '{"R4", 1'b1, {6'h39, 5'd2, 21'h1FFFFD},   62'h200,  64'hFFFF_FFFF_FFFF_FFFF, 64'd0},
        '{"R3", 1'b1, {6'h3A, 5'd3, 21'd7},        62'h300,  64'h8000_0000_0000_0000, 64'd0},
        '{"R3", 1'b0, {6'h3A, 5'd3, 21'd7},        62'h300,  64'd0,  64'd0},
        '{"R3", 1'b1, {6'h3B, 5'd4, 21'd9},        62'h400,  64'd0,  64'd0},
        '{"R3", 1'b1, {6'h3C, 5'd4, 21'd9},        62'h400,  64'd0,  64'd0},
        '{"R3", 1'b0, {6'h3D, 5'd4, 21'd9},        62'h400,  64'd0,  64'd0},
        '{"R3", 1'b1, {6'h3D, 5'd4, 21'd9},        62'h400,  64'd5,  64'd0},
        '{"R4", 1'b1, {6'h30, 5'd2, 21'h100000},   62'h10,   64'd0,  64'd0},
        '{"R5", 1'b1, {6'h30, 5'd6, 21'h0FFFFF},   62'h3FFF_FFFF_FFFF_FFF0, 64'd0, 64'd0},
        '{"R7", 1'b1, {6'h1A, 5'd7, 5'd8, 2'b00, 14'h1234}, 62'h500, 64'd0, 64'hDEAD_BEEF_0000_1237},
        '{"R11", 1'b0, {6'h10, 5'd1, 21'd3},       62'h600,  64'd0,  64'd0},
        '{"R11", 1'b0, {6'h3E, 5'd0, 21'd3},       62'h600,  64'd0,  64'd0}
    };

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [61:0] pc, input logic [63:0] ra,
                       input logic [63:0] rb, input string tag);
        logic [5:0]  op;
        logic [4:0]  rai;
        logic [63:0] seq, rel, tgt, pred;
        logic        tk, lk, ps, pp;
        op   = ins[31:26];
        rai  = ins[25:21];
        seq  = {pc, 2'b00} + 64'd4;
        rel  = seq + {{41{ins[20]}}, ins[20:0], 2'b00};
        tk = 1'b0; lk = 1'b0; ps = 1'b0; pp = 1'b0; tgt = rel; pred = '0;
        case (op)
            6'h38: tk = (ra == 0);
            6'h39: tk = (ra != 0);
            6'h3A: tk = $signed(ra) < 0;
            6'h3B: tk = $signed(ra) >= 0;
            6'h3C: tk = $signed(ra) <= 0;
            6'h3D: tk = $signed(ra) > 0;
            6'h30: begin tk = 1'b1; lk = 1'b1; end
            6'h34: begin tk = 1'b1; lk = 1'b1; ps = 1'b1; end
            6'h1A: begin
                tk = 1'b1; lk = 1'b1; tgt = {rb[63:2], 2'b00};
                ps = (ins[15:14] == 2'b01) || (ins[15:14] == 2'b11);
                pp = ins[15:14][1];
            end
            default: tk = 1'b0;
        endcase
        if (rai == 5'd31) lk = 1'b0;
        if (pp) pred = mstk[msp - 3'd1];
        if (ps && pp) mstk[msp - 3'd1] = seq;
        else if (ps) begin mstk[msp] = seq; msp = msp + 3'd1; end
        else if (pp) msp = msp - 3'd1;
        @(negedge clk);
        valid_i = 1'b1; instr_i = ins; pc_i = pc; ra_val_i = ra; rb_val_i = rb;
        @(negedge clk);
        valid_i = 1'b0;
        chk(tag, "out_valid", 64'(out_valid_o), 64'd1);
        chk(tag, "taken", 64'(taken_o), 64'(tk));
        chk(tag, "next_pc", next_pc_o, tk ? tgt : seq);
        chk(tag, "link_we", 64'(link_we_o), 64'(lk));
        chk(tag, "link_reg", 64'(link_reg_o), lk ? 64'(rai) : 64'd0);
        chk(tag, "link_data", link_data_o, lk ? seq : 64'd0);
        chk(tag, "push", 64'(ras_push_o), 64'(ps));
        chk(tag, "pop", 64'(ras_pop_o), 64'(pp));
        chk(tag, "pred", ras_pred_o, pred);
    endtask

    function automatic logic [31:0] jmp(input logic [4:0] ra, input logic [4:0] rb,
                                        input logic [1:0] k, input logic [13:0] hint);
        return {6'h1A, ra, rb, k, hint};
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) mstk[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid in reset", 64'(out_valid_o), 64'd0);
        chk("R1", "taken in reset", 64'(taken_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "link_we after reset", 64'(link_we_o), 64'd0);
        chk("R1", "push/pop after reset", 64'({ras_push_o, ras_pop_o}), 64'd0);
        run(jmp(5'd1, 5'd2, 2'b10, 14'd0), 62'h40, 64'd0, 64'h80, "R1");

        for (int v = 0; v < NVEC; v++) begin
            run(TBL[v].ins, TBL[v].pc, TBL[v].ra, TBL[v].rb, string'(TBL[v].tag));
            chk(string'(TBL[v].tag), "table taken", 64'(taken_o), 64'(TBL[v].exp_taken));
        end

        // R6: branch-to-subroutine pushes, plain branch does not
        run({6'h34, 5'd26, 21'd16}, 62'h1000, 64'd0, 64'd0, "R6");
        run({6'h30, 5'd2, 21'd4}, 62'h2000, 64'd0, 64'd0, "R6");
        run(jmp(5'd31, 5'd26, 2'b10, 14'd0), 62'h3000, 64'd0, 64'h4004, "R6");

        // R2: an instruction without valid changes nothing
        run({6'h34, 5'd26, 21'd16}, 62'h1100, 64'd0, 64'd0, "R2");
        @(negedge clk);
        valid_i = 1'b0; instr_i = {6'h34, 5'd26, 21'd16}; pc_i = 62'h7777;
        @(negedge clk);
        chk("R2", "out_valid idle", 64'(out_valid_o), 64'd0);
        chk("R2", "taken idle", 64'(taken_o), 64'd0);
        chk("R2", "push idle", 64'(ras_push_o), 64'd0);
        run(jmp(5'd31, 5'd26, 2'b10, 14'd0), 62'h3100, 64'd0, 64'd0, "R2");

        // R7: Ra and Rb the same register, old Rb used for target
        run(jmp(5'd5, 5'd5, 2'b01, 14'd0), 62'h900, 64'd0, 64'h0000_0000_00AB_CDE3, "R7");
        // R8: coroutine swaps top, hint bits ignored
        run(jmp(5'd6, 5'd7, 2'b11, 14'h3FFF), 62'hA00, 64'd0, 64'h123, "R8");
        run(jmp(5'd6, 5'd7, 2'b10, 14'h2AAA), 62'hB00, 64'd0, 64'h456, "R8");
        run(jmp(5'd6, 5'd7, 2'b00, 14'h3FFF), 62'hB80, 64'd0, 64'h456, "R8");
        // R10: link to register 31 suppressed, stack still acts
        run({6'h34, 5'd31, 21'd2}, 62'hC00, 64'd0, 64'd0, "R10");
        run(jmp(5'd31, 5'd3, 2'b10, 14'd0), 62'hD00, 64'd0, 64'h88, "R10");
        // R9: nine pushes then nine pops, wrap
        for (int k = 0; k < 9; k++)
            run({6'h34, 5'd26, 21'd1}, 62'h5000 + 62'(k * 16), 64'd0, 64'd0, "R9");
        for (int k = 0; k < 9; k++)
            run(jmp(5'd31, 5'd26, 2'b10, 14'd0), 62'h6000, 64'd0, 64'h10, "R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule